// File: doc/BRIEF.md
# Command/Indicate Channel Monitor

This block sits between a frame deserializer and a link-layer controller on a periodic framed serial bus. The bus carries two command/indicate status channels. Once per frame a strobe shows that fresh receive code fields are present. The block keeps the accepted receive code of each channel in registers that software can read. It flags code changes as sticky interrupt status bits, and it sends the contents of two writable transmit registers on every frame.

The two receive channels filter their codes in different ways. The 4-bit primary channel accepts a new value only after the same value has arrived on two strobes in a row. A value that appears for only one frame is discarded. The 6-bit secondary channel reports any new value at once. The secondary channel is active only while the bus runs in terminal timing mode. Outside that mode its receive path is frozen and its transmit field idles at all ones.

Registers are reached through a 3-bit address. Writes use a single-cycle write strobe. Read data is combinational on the address.

Top module: `cmdind_monitor`

## Requirements
- R1: After reset, both accepted receive codes and both transmit registers are all ones, the status (address 4) and mask (address 5) registers are zero, and `irq` is low.
- R2: A primary receive value that differs from the accepted code and arrives on two consecutive strobes becomes the accepted code on the second strobe, and status bit 0 is set on the same edge.
- R3: A primary value seen on only one strobe is never accepted. If the next strobe brings a different value, that value becomes the new candidate, and no status bit 0 is raised until some value repeats.
- R4: In terminal mode (`term_mode`=1), a strobe whose secondary value differs from the accepted secondary code updates that code and sets status bit 1 on the same edge.
- R5: With `term_mode`=0, secondary receive values are ignored (no code update, no status bit 1), and `tx_sec` is all ones.
- R6: Without `frame_stb`, the receive inputs have no effect on any accepted code, candidate or status bit.
- R7: `tx_pri` (written at address 2) and `tx_sec` in terminal mode (written at address 3) hold the last written value on every cycle until they are rewritten.
- R8: Status bits are sticky. Writing 1 to a bit at address 4 clears it. A change event in the same cycle as a clear leaves the bit set.
- R9: `irq` is the OR of the status bits whose matching mask bit (address 5, 1 = masked) is 0.
- R10: Reads return the accepted primary code at address 0, the accepted secondary code at address 1, the transmit registers at addresses 2 and 3, and status and mask at addresses 4 and 5, zero-extended. A read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe marking valid receive fields for a frame |
| term_mode | input | 1 | 1 = terminal timing mode; enables the secondary channel |
| rx_pri | input | 4 | Primary receive code of the current frame |
| rx_sec | input | 6 | Secondary receive code of the current frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data (combinational on address) |
| tx_pri | output | 4 | Primary transmit code |
| tx_sec | output | 6 | Secondary transmit code, all ones outside terminal mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks that a primary value seen on one frame is never accepted, even when it sits between two different values. A filter that accepted on the first sighting, or that compared against the accepted code instead of the previous frame's value, would raise status bit 0 on a glitch. The bench also covers:
- a write-1 clear landing in the same cycle as a secondary change, where a design that gave the clear priority would lose the event;
- strobes in non-terminal mode, where a missing gate would update the secondary code or let the transmit field leak;
- repeated reads of status and codes, where a read-to-clear design would drop pending interrupts;
- idle cycles with changing receive inputs, where ungated sampling would move the codes.

// File: rtl/cmdind_pkg.sv
package cmdind_pkg;

    typedef enum logic [2:0] {
        ADR_RX_PRI = 3'd0,
        ADR_RX_SEC = 3'd1,
        ADR_TX_PRI = 3'd2,
        ADR_TX_SEC = 3'd3,
        ADR_STATUS = 3'd4,
        ADR_MASK   = 3'd5
    } reg_addr_e;

    localparam int ST_PRI = 0;
    localparam int ST_SEC = 1;
    localparam int ST_W   = 2;

endpackage

// File: rtl/cmdind_dll_filter.sv
module cmdind_dll_filter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] rx,
    output logic [W-1:0] code,
    output logic         chg
);

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] prev;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        chg  = 1'b0;
        if (stb) begin
            st_d.prev = rx;
            if ((rx == st_q.prev) && (rx != st_q.acc)) begin
                st_d.acc = rx;
                chg      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc: '1, prev: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.acc;

    AST_PRI_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(code)); // R6

    AST_PRI_NO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && (rx != st_q.prev)) |=> $stable(code)); // R3

endmodule

// File: rtl/cmdind_chg_detect.sv
module cmdind_chg_detect #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         en,
    input  logic [W-1:0] rx,
    output logic [W-1:0] code,
    output logic         chg
);

    logic [W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        chg    = 1'b0;
        if (stb && en && (rx != code_q)) begin
            code_d = rx;
            chg    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '1;
        end else begin
            code_q <= code_d;
        end
    end

    assign code = code_q;

    AST_SEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && en) |=> $stable(code)); // R5

    AST_SEC_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && en) |=> (code == $past(rx))); // R4

endmodule

// File: rtl/cmdind_monitor.sv
module cmdind_monitor
    import cmdind_pkg::*;
#(
    parameter int PW = 4,
    parameter int SW = 6,
    parameter int DW = (SW > PW) ? SW : PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          term_mode,
    input  logic [PW-1:0] rx_pri,
    input  logic [SW-1:0] rx_sec,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [PW-1:0] tx_pri,
    output logic [SW-1:0] tx_sec,
    output logic          irq
);

    typedef struct packed {
        logic [PW-1:0]   txp;
        logic [SW-1:0]   txs;
        logic [ST_W-1:0] status;
        logic [ST_W-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [PW-1:0] pri_code;
    logic [SW-1:0] sec_code;
    logic          pri_chg, sec_chg;

    cmdind_dll_filter #(.W(PW)) u_pri (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (frame_stb),
        .rx   (rx_pri),
        .code (pri_code),
        .chg  (pri_chg)
    );

    cmdind_chg_detect #(.W(SW)) u_sec (
        .clk  (clk),
        .rst_n(rst_n),
        .stb  (frame_stb),
        .en   (term_mode),
        .rx   (rx_sec),
        .code (sec_code),
        .chg  (sec_chg)
    );

    logic            wr_status;
    logic [ST_W-1:0] clr_bits;
    logic [ST_W-1:0] set_bits;

    always_comb begin
        wr_status = reg_wr && (reg_addr == ADR_STATUS);
        clr_bits  = wr_status ? reg_wdata[ST_W-1:0] : '0;
        set_bits  = '0;
        set_bits[ST_PRI] = pri_chg;
        set_bits[ST_SEC] = sec_chg;

        r_d = r_q;
        r_d.status = (r_q.status & ~clr_bits) | set_bits;
        if (reg_wr) begin
            case (reg_addr)
                ADR_TX_PRI: r_d.txp  = reg_wdata[PW-1:0];
                ADR_TX_SEC: r_d.txs  = reg_wdata[SW-1:0];
                ADR_MASK:   r_d.mask = reg_wdata[ST_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{txp: '1, txs: '1, status: '0, mask: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_RX_PRI: reg_rdata[PW-1:0]   = pri_code;
            ADR_RX_SEC: reg_rdata[SW-1:0]   = sec_code;
            ADR_TX_PRI: reg_rdata[PW-1:0]   = r_q.txp;
            ADR_TX_SEC: reg_rdata[SW-1:0]   = r_q.txs;
            ADR_STATUS: reg_rdata[ST_W-1:0] = r_q.status;
            ADR_MASK:   reg_rdata[ST_W-1:0] = r_q.mask;
            default:    reg_rdata = '0;
        endcase
    end

    assign tx_pri = r_q.txp;
    assign tx_sec = term_mode ? r_q.txs : '1;
    assign irq    = |(r_q.status & ~r_q.mask);

    AST_TX_PRI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == ADR_TX_PRI)) |=> $stable(tx_pri)); // R7

    AST_PRI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.status[ST_PRI] && !(wr_status && reg_wdata[ST_PRI]))
        |=> r_q.status[ST_PRI]); // R8

    AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.status[ST_SEC] && !(wr_status && reg_wdata[ST_SEC]))
        |=> r_q.status[ST_SEC]); // R8

    AST_PRI_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (rx_pri != pri_code)) ##1 (pri_code != $past(pri_code))
        |-> r_q.status[ST_PRI]); // R2

endmodule

// File: tb/cmdind_monitor_test.sv
module cmdind_monitor_test;

    localparam int PW = 4;
    localparam int SW = 6;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_stb = 1'b0;
    logic          term_mode = 1'b1;
    logic [PW-1:0] rx_pri = '1;
    logic [SW-1:0] rx_sec = '1;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [PW-1:0] tx_pri;
    logic [SW-1:0] tx_sec;
    logic          irq;

    always #2 clk = ~clk;

    cmdind_monitor uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .term_mode(term_mode),
        .rx_pri(rx_pri), .rx_sec(rx_sec), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pri(tx_pri),
        .tx_sec(tx_sec), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [PW-1:0] m_pv = '1, m_pp = '1, m_tp = '1;
    logic [SW-1:0] m_sv = '1, m_ts = '1;
    logic [1:0]    m_st = '0, m_mk = '0;

    function automatic logic [DW-1:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return DW'(m_pv);
            3'd1: return DW'(m_sv);
            3'd2: return DW'(m_tp);
            3'd3: return DW'(m_ts);
            3'd4: return DW'(m_st);
            3'd5: return DW'(m_mk);
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_st & ~m_mk);
    endfunction

    function automatic logic [SW-1:0] exp_txs(input logic tm);
        return tm ? m_ts : '1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic s, input logic tm, input logic [PW-1:0] rp,
                              input logic [SW-1:0] rs, input logic w,
                              input logic [2:0] a, input logic [DW-1:0] d);
        logic [1:0] setb, clrb;
        setb = '0;
        clrb = (w && a == 3'd4) ? d[1:0] : 2'b00;
        if (s) begin
            if (rp == m_pp && rp != m_pv) begin m_pv = rp; setb[0] = 1'b1; end
            m_pp = rp;
            if (tm && rs != m_sv) begin m_sv = rs; setb[1] = 1'b1; end
        end
        m_st = (m_st & ~clrb) | setb;
        if (w) begin
            if (a == 3'd2) m_tp = d[PW-1:0];
            if (a == 3'd3) m_ts = d[SW-1:0];
            if (a == 3'd5) m_mk = d[1:0];
        end
    endtask

    task automatic cyc(input logic s, input logic tm, input logic [PW-1:0] rp,
                       input logic [SW-1:0] rs, input logic w,
                       input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        frame_stb = s; term_mode = tm; rx_pri = rp; rx_sec = rs;
        reg_wr = w; reg_addr = a; reg_wdata = d;
        model_step(s, tm, rp, rs, w, a, d);
        @(posedge clk);
        #1;
        chk("R10 rdata", 32'(reg_rdata), 32'(exp_rd(a)));
        chk("R9 irq", 32'(irq), 32'(exp_irq()));
        chk("R7 tx_pri", 32'(tx_pri), 32'(m_tp));
        chk("R5 tx_sec", 32'(tx_sec), 32'(exp_txs(tm)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cyc(0, 1, 4'hF, 6'h3F, 0, 3'd0, 0);
        chk("R1 rx_pri reg", 32'(reg_rdata), 32'h0F);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_pri", 32'(tx_pri), 32'hF);
        chk("R1 tx_sec", 32'(tx_sec), 32'h3F);
        cyc(0, 1, 4'hF, 6'h3F, 0, 3'd4, 0);
        chk("R1 status", 32'(reg_rdata), 0);

        // R3: single sightings, candidate replaced
        cyc(1, 1, 4'h5, 6'h3F, 0, 3'd4, 0);
        cyc(1, 1, 4'h6, 6'h3F, 0, 3'd4, 0);
        chk("R3 no status on single frame", 32'(reg_rdata), 0);
        // R2: repeat accepted
        cyc(1, 1, 4'h6, 6'h3F, 0, 3'd4, 0);
        chk("R2 status bit0", 32'(reg_rdata), 32'h1);
        cyc(0, 1, 4'h6, 6'h3F, 0, 3'd0, 0);
        chk("R2 accepted code", 32'(reg_rdata), 32'h6);
        cyc(0, 1, 4'h6, 6'h3F, 0, 3'd4, 0);
        chk("R10 read keeps status", 32'(reg_rdata), 32'h1);

        // R6: no strobe, inputs ignored
        cyc(0, 1, 4'h9, 6'h11, 0, 3'd0, 0);
        cyc(0, 1, 4'h9, 6'h11, 0, 3'd0, 0);
        chk("R6 code held", 32'(reg_rdata), 32'h6);

        // R4: secondary immediate
        cyc(1, 1, 4'h6, 6'h15, 0, 3'd4, 0);
        chk("R4 status bit1", 32'(reg_rdata), 32'h3);

        // R8: set beats clear
        cyc(1, 1, 4'h6, 6'h2A, 1, 3'd4, 6'h3);
        cyc(0, 1, 4'h6, 6'h2A, 0, 3'd4, 0);
        chk("R8 set wins", 32'(reg_rdata), 32'h2);
        cyc(0, 1, 4'h6, 6'h2A, 1, 3'd4, 6'h2);
        cyc(0, 1, 4'h6, 6'h2A, 0, 3'd4, 0);
        chk("R8 cleared", 32'(reg_rdata), 0);

        // R9: masking
        cyc(1, 1, 4'h6, 6'h2B, 0, 3'd4, 0);
        chk("R9 irq raised", 32'(irq), 1);
        cyc(0, 1, 4'h6, 6'h2B, 1, 3'd5, 6'h2);
        chk("R9 irq masked", 32'(irq), 0);

        // R5: non-terminal mode
        cyc(1, 0, 4'h6, 6'h01, 0, 3'd1, 0);
        chk("R5 sec code held", 32'(reg_rdata), 32'h2B);
        chk("R5 tx_sec idle", 32'(tx_sec), 32'h3F);
        cyc(0, 0, 4'h6, 6'h01, 0, 3'd4, 0);
        chk("R5 no status", 32'(reg_rdata), 32'h2);

        // R7: transmit registers held
        cyc(0, 1, 4'h6, 6'h2B, 1, 3'd2, 6'h0A);
        cyc(0, 1, 4'h6, 6'h2B, 1, 3'd3, 6'h12);
        cyc(1, 1, 4'h3, 6'h07, 0, 3'd0, 0);
        chk("R7 tx_pri held", 32'(tx_pri), 32'hA);
        chk("R7 tx_sec held", 32'(tx_sec), 32'h12);

        for (int i = 0; i < 4000; i++) begin
            logic s, tm, w;
            logic [2:0] a;
            logic [PW-1:0] rp;
            logic [SW-1:0] rs;
            logic [DW-1:0] d;
            s  = ($urandom % 2) == 0;
            tm = ($urandom % 8) != 0;
            w  = ($urandom % 5) == 0;
            a  = 3'($urandom % 6);
            rp = 4'(($urandom % 3) + 4'h4);
            rs = 6'(($urandom % 4) + 6'h10);
            d  = 6'($urandom);
            cyc(s, tm, rp, rs, w, a, d);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule